// File: doc/BRIEF.md
# Length-Detecting Three-Wire Control Receiver

This block takes control words from a three-wire serial link: a framing strobe, a data line and a serial clock. All three lines are already synchronized to the system clock. While the strobe is high, the block shifts in one bit on every falling edge of the serial clock and counts the bits it has received.

The count tells the block which register fields the word updates and when each update takes effect. The port field commits early in the transfer. The frequency field commits either at the end of the word or at a fixed clock edge partway through it, depending on the word's length. The control field commits only when the strobe falls at the end of a full-length word.

The two shorter legal lengths also set the reference-ratio select bit on their own, so a host can pick the step size just by choosing the word length. Words of an unsupported length leave the control fields alone and set a sticky error flag. A mode input lets the surrounding bus logic switch the receiver off completely.

Top module: `tw_len_rx`

## Requirements
- R1: After reset the port field is 0, the frequency field is 0, the charge-pump bit is 1, the test field is 3'b001, both ratio-select bits are 1, the output-off bit is 1 and the error flag is 0.
- R2: A bit is taken from the data line on each falling edge of the serial clock while the strobe is high. The first four bits, first one into port bit 3, commit to the port field on the 5th rising edge of the serial clock.
- R3: A word of 18 bits commits its last 14 bits to frequency bits 13..0 when the strobe falls, forces frequency bit 14 to 0 and sets the ratio-select-A bit to 1.
- R4: A word of 19 bits commits its last 15 bits to the frequency field when the strobe falls and clears the ratio-select-A bit to 0.
- R5: In a 27-bit word, bits 5..19 commit to the frequency field on the 20th rising serial-clock edge, before the strobe falls. Bit 20 is ignored. Bits 21..27 (charge pump, test 2..0, ratio-select A, ratio-select B, output-off, in that order) commit when the strobe falls.
- R6: Words of 18 or 19 bits leave the charge-pump, test, ratio-select-B and output-off bits unchanged.
- R7: A word shorter than 18 bits leaves the frequency and control fields unchanged and does not set the error flag.
- R8: A word of 20 to 26 bits, or longer than 27 bits, leaves the control fields unchanged and sets the error flag. The flag stays set until reset. The frequency field of such a word still commits on the 20th rising edge.
- R9: The bit counter saturates, so a very long word (for example 59 bits) is never mistaken for a legal length.
- R10: The bit counter clears on each rising edge of the strobe, so each word is measured on its own.
- R11: While the mode-enable input is low, the receiver ignores all traffic and no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Receiver enable from bus-mode selection |
| strobe_i | input | 1 | Framing strobe, high during a word |
| sdat_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock |
| port_o | output | 4 | Port switch field |
| freq_o | output | 15 | Programmable divider field |
| cp_o | output | 1 | Charge-pump current select |
| tst_o | output | 3 | Test mode field |
| rsa_o | output | 1 | Ratio-select A |
| rsb_o | output | 1 | Ratio-select B |
| off_o | output | 1 | Tuning output off |
| len_err_o | output | 1 | Sticky bad-length flag |

## Verification
On every cycle the assertions check four things. The port, frequency and control fields change only on the edge events their length rules allow. An 18-bit commit leaves frequency bit 14 at zero with ratio-select A set, and a 19-bit commit leaves ratio-select A clear. The error flag never drops, and a saturated counter stays saturated.

Only the bench's scenarios can show the exact values that reach each field. They also show that the frequency of a long word appears before the strobe falls, and that a 59-bit word is not folded into a legal 27-bit one. Two further effects need whole words to observe: a short word is harmless, and a disabled receiver leaves every field as it was.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
   typedef struct packed {
      logic       cp;
      logic [2:0] tst;
      logic       rsa;
      logic       rsb;
      logic       off;
   } tw_ctrl_t;

   localparam int unsigned CTRL_W = $bits(tw_ctrl_t);

   localparam tw_ctrl_t CTRL_RST = '{cp: 1'b1, tst: 3'b001, rsa: 1'b1, rsb: 1'b1, off: 1'b1};
endpackage

// File: rtl/tw_edge.sv
`timescale 1ns/1ps
module tw_edge #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev;

   if (N < 1) begin : g_bad_n
      $error("tw_edge: N must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign rise[i] = lvl[i] & ~prev[i];
      assign fall[i] = ~lvl[i] & prev[i];
   end
endmodule

// File: rtl/tw_shifter.sv
`timescale 1ns/1ps
module tw_shifter #(
   parameter int unsigned SR_W    = 15,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned CNT_LIM = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             din,
   output logic [CNT_W-1:0] cnt,
   output logic [SR_W-1:0]  sr
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(CNT_LIM);

   if (CNT_LIM >= (1 << CNT_W)) begin : g_bad_cnt
      $error("tw_shifter: CNT_W too narrow for CNT_LIM");
   end
   if (SR_W < 2) begin : g_bad_sr
      $error("tw_shifter: SR_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (shift) begin
         sr <= {sr[SR_W-2:0], din};
         if (cnt != LIM) cnt <= cnt + 1'b1;
      end
   end

   // R9
   cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LIM && shift && !clr) |=> (cnt == LIM));
endmodule

// File: rtl/tw_regs.sv
`timescale 1ns/1ps
module tw_regs
   import tw_pkg::*;
#(
   parameter int unsigned PORT_W = 4,
   parameter int unsigned FREQ_W = 15,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned LEN_A  = 18,
   parameter int unsigned LEN_B  = 19,
   parameter int unsigned LEN_C  = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_act,
   input  logic              end_ev,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [FREQ_W-1:0] sr,
   output logic [PORT_W-1:0] port_q,
   output logic [FREQ_W-1:0] freq_q,
   output tw_ctrl_t          ctrl_q,
   output logic              err_q
);
   localparam logic [CNT_W-1:0] KP = CNT_W'(PORT_W);
   localparam logic [CNT_W-1:0] KA = CNT_W'(LEN_A);
   localparam logic [CNT_W-1:0] KB = CNT_W'(LEN_B);
   localparam logic [CNT_W-1:0] KC = CNT_W'(LEN_C);

   logic port_ld, mid_ld;
   assign port_ld = edge_act && (cnt == KP);
   assign mid_ld  = edge_act && (cnt == KB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
         freq_q <= '0;
         ctrl_q <= CTRL_RST;
         err_q  <= 1'b0;
      end else begin
         if (port_ld) port_q <= sr[PORT_W-1:0];
         if (mid_ld)  freq_q <= sr;
         if (end_ev) begin
            if (cnt == KA) begin
               freq_q     <= {1'b0, sr[FREQ_W-2:0]};
               ctrl_q.rsa <= 1'b1;
            end else if (cnt == KB) begin
               freq_q     <= sr;
               ctrl_q.rsa <= 1'b0;
            end else if (cnt == KC) begin
               ctrl_q <= tw_ctrl_t'(sr[CTRL_W-1:0]);
            end else if (cnt > KB) begin
               err_q <= 1'b1;
            end
         end
      end
   end

   // R2
   port_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_q) |-> $past(edge_act && cnt == KP));
   // R7
   freq_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq_q) |-> $past((end_ev && (cnt == KA || cnt == KB)) || (edge_act && cnt == KB)));
   // R3
   len_a_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_ev && cnt == KA) |=> (!freq_q[FREQ_W-1] && ctrl_q.rsa));
   // R4
   len_b_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_ev && cnt == KB) |=> !ctrl_q.rsa);
   // R6
   ctrl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ctrl_q.cp, ctrl_q.tst, ctrl_q.rsb, ctrl_q.off}) |-> $past(end_ev && cnt == KC));
   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/tw_len_rx.sv
`timescale 1ns/1ps
module tw_len_rx
   import tw_pkg::*;
#(
   parameter int unsigned PORT_W   = 4,
   parameter int unsigned FREQ_W   = 15,
   parameter int unsigned SPACER_W = 1,
   parameter int unsigned LEN_A    = 18,
   parameter int unsigned LEN_B    = 19,
   parameter int unsigned LEN_C    = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              strobe_i,
   input  logic              sdat_i,
   input  logic              sclk_i,
   output logic [PORT_W-1:0] port_o,
   output logic [FREQ_W-1:0] freq_o,
   output logic              cp_o,
   output logic [2:0]        tst_o,
   output logic              rsa_o,
   output logic              rsb_o,
   output logic              off_o,
   output logic              len_err_o
);
   localparam int unsigned CNT_LIM = LEN_C + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_LIM + 1);

   if (LEN_B != PORT_W + FREQ_W) begin : g_bad_b
      $error("tw_len_rx: LEN_B must equal PORT_W + FREQ_W");
   end
   if (LEN_A != LEN_B - 1) begin : g_bad_a
      $error("tw_len_rx: LEN_A must be LEN_B - 1");
   end
   if (LEN_C != LEN_B + SPACER_W + CTRL_W) begin : g_bad_c
      $error("tw_len_rx: LEN_C must cover the control field");
   end
   if (CTRL_W > FREQ_W || PORT_W > FREQ_W) begin : g_bad_w
      $error("tw_len_rx: fields must fit the shift register");
   end

   // line 0: strobe, line 1: serial clock
   logic [1:0] rise, fall;
   tw_edge #(.N(2)) i_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({sclk_i, strobe_i}),
      .rise (rise),
      .fall (fall)
   );

   logic clr, shift, edge_act, end_ev;
   assign clr      = bus_en && rise[0];
   assign shift    = bus_en && strobe_i && fall[1];
   assign edge_act = bus_en && strobe_i && rise[1];
   assign end_ev   = bus_en && fall[0];

   logic [CNT_W-1:0]  cnt;
   logic [FREQ_W-1:0] sr;
   tw_shifter #(.SR_W(FREQ_W), .CNT_W(CNT_W), .CNT_LIM(CNT_LIM)) i_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .shift(shift),
      .din  (sdat_i),
      .cnt  (cnt),
      .sr   (sr)
   );

   tw_ctrl_t ctrl_q;
   tw_regs #(
      .PORT_W(PORT_W), .FREQ_W(FREQ_W), .CNT_W(CNT_W),
      .LEN_A (LEN_A),  .LEN_B (LEN_B),  .LEN_C(LEN_C)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_act(edge_act),
      .end_ev  (end_ev),
      .cnt     (cnt),
      .sr      (sr),
      .port_q  (port_o),
      .freq_q  (freq_o),
      .ctrl_q  (ctrl_q),
      .err_q   (len_err_o)
   );

   assign cp_o  = ctrl_q.cp;
   assign tst_o = ctrl_q.tst;
   assign rsa_o = ctrl_q.rsa;
   assign rsb_o = ctrl_q.rsb;
   assign off_o = ctrl_q.off;

   // R11
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_en && $past(!bus_en)) |-> ($stable(port_o) && $stable(freq_o) && $stable(len_err_o)));
endmodule

// File: tb/test_tw_len_rx.sv
`timescale 1ns/1ps
module test_tw_len_rx;
   logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b1;
   logic strobe = 1'b0, sdat = 1'b0, sclk = 1'b0;
   logic [3:0]  port_o;
   logic [14:0] freq_o;
   logic cp_o, rsa_o, rsb_o, off_o, len_err_o;
   logic [2:0] tst_o;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tw_len_rx i_tw_len_rx (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
      .strobe_i(strobe), .sdat_i(sdat), .sclk_i(sclk),
      .port_o(port_o), .freq_o(freq_o), .cp_o(cp_o), .tst_o(tst_o),
      .rsa_o(rsa_o), .rsb_o(rsb_o), .off_o(off_o), .len_err_o(len_err_o)
   );

   function automatic logic [6:0] ctrl_now();
      return {cp_o, tst_o, rsa_o, rsb_o, off_o};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; strobe = 1'b0; sclk = 1'b0; sdat = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic str_up();   strobe = 1'b1; tick(3); endtask
   task automatic str_down(); strobe = 1'b0; tick(3); endtask
   task automatic bit_rise(input logic b); sdat = b; tick(2); sclk = 1'b1; tick(2); endtask
   task automatic bit_fall(); sclk = 1'b0; tick(2); endtask

   task automatic send(input int n, input logic [63:0] w);
      str_up();
      for (int i = n - 1; i >= 0; i--) begin
         bit_rise(w[i]);
         bit_fall();
      end
      str_down();
   endtask

   task automatic t_reset();
      chk("R1 port", 32'(port_o), 32'h0);
      chk("R1 freq", 32'(freq_o), 32'h0);
      chk("R1 ctrl", 32'(ctrl_now()), 32'h4F);
      chk("R1 err", 32'(len_err_o), 32'h0);
   endtask

   task automatic t_word19();
      send(19, 64'({4'b0101, 15'h5A3C}));
      chk("R2 port", 32'(port_o), 32'h5);
      chk("R4 freq", 32'(freq_o), 32'h5A3C);
      chk("R4 R6 ctrl", 32'(ctrl_now()), 32'h4B);
      chk("R4 err", 32'(len_err_o), 32'h0);
   endtask

   task automatic t_word18();
      send(18, 64'({4'b1010, 14'h2FFF}));
      chk("R2 port", 32'(port_o), 32'hA);
      chk("R3 freq", 32'(freq_o), 32'h2FFF);
      chk("R3 R6 ctrl", 32'(ctrl_now()), 32'h4F);
   endtask

   task automatic t_word27();
      logic [26:0] w;
      w = {4'b0011, 15'h1234, 1'b1, 7'b0110000};
      str_up();
      for (int i = 26; i >= 8; i--) begin
         bit_rise(w[i]);
         bit_fall();
      end
      chk("R5 freq before 20th rise", 32'(freq_o), 32'h2FFF);
      bit_rise(w[7]);
      chk("R5 freq at 20th rise", 32'(freq_o), 32'h1234);
      bit_fall();
      for (int i = 6; i >= 0; i--) begin
         bit_rise(w[i]);
         bit_fall();
      end
      chk("R5 ctrl before strobe fall", 32'(ctrl_now()), 32'h4F);
      str_down();
      chk("R5 ctrl", 32'(ctrl_now()), 32'h30);
      chk("R5 freq", 32'(freq_o), 32'h1234);
      chk("R2 port", 32'(port_o), 32'h3);
      chk("R5 err", 32'(len_err_o), 32'h0);
   endtask

   task automatic t_short();
      send(10, 64'({4'b0110, 6'h3F}));
      chk("R7 freq", 32'(freq_o), 32'h1234);
      chk("R7 ctrl", 32'(ctrl_now()), 32'h30);
      chk("R7 err", 32'(len_err_o), 32'h0);
      chk("R2 port short", 32'(port_o), 32'h6);
   endtask

   task automatic t_clear();
      send(18, 64'({4'b1001, 14'h0155}));
      chk("R10 freq", 32'(freq_o), 32'h0155);
      chk("R10 err", 32'(len_err_o), 32'h0);
      chk("R10 ctrl", 32'(ctrl_now()), 32'h34);
   endtask

   task automatic t_bad22();
      send(22, 64'({4'b1100, 15'h0777, 3'b101}));
      chk("R8 err", 32'(len_err_o), 32'h1);
      chk("R8 ctrl", 32'(ctrl_now()), 32'h34);
      chk("R8 freq", 32'(freq_o), 32'h0777);
   endtask

   task automatic t_sticky();
      send(19, 64'({4'b0001, 15'h4321}));
      chk("R8 sticky err", 32'(len_err_o), 32'h1);
      chk("R4 freq", 32'(freq_o), 32'h4321);
   endtask

   task automatic t_long59();
      do_reset();
      send(59, 64'h07FF_FFFF_FFFF_FF80);
      chk("R9 err", 32'(len_err_o), 32'h1);
      chk("R9 ctrl", 32'(ctrl_now()), 32'h4F);
   endtask

   task automatic t_disabled();
      do_reset();
      bus_en = 1'b0;
      send(19, 64'({4'b1111, 15'h7FFF}));
      chk("R11 port", 32'(port_o), 32'h0);
      chk("R11 freq", 32'(freq_o), 32'h0);
      chk("R11 ctrl", 32'(ctrl_now()), 32'h4F);
      bus_en = 1'b1;
      tick(2);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_word19();
      t_word18();
      t_word27();
      t_short();
      t_clear();
      t_bad22();
      t_sticky();
      t_long59();
      t_disabled();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule